// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver Section

This block is one section of a bus transceiver that sits between two parallel buses, called side A and side B. For each direction it holds a storage register, plus a selector that chooses what goes to the far side. The selector passes either the live value from the near bus or the last stored copy. Output enables are separate per-side signals rather than tri-state pins, so the section fits inside a larger core. The enclosing pad ring, or a bench, resolves each enable into a real bus drive.

One active-low enable and one direction control decide which side, if any, is driven. A separate capture strobe for each direction loads that direction's register on the strobe's rising edge, as seen by the core clock. Capture does not depend on the enable or the direction setting. A value can therefore be stored while both buses are isolated and replayed later, in either direction. To build a wider bus, place several sections side by side and share their controls. Sections with separate controls work independently.

Top module: `bidir_xcvr_sec`

## Requirements
- R1: A clock edge with `rst_n` low clears both storage registers to zero. This is observed through the stored path once reset is released.
- R2: While `oe_n` is high, `a_oe` and `b_oe` are both 0, and `a_out` and `b_out` are both all zeros.
- R3: With `oe_n` low and `dir` high, `b_oe` is 1 and `a_oe` is 0, so the section drives side B only.
- R4: With `oe_n` low and `dir` low, `a_oe` is 1 and `b_oe` is 0, so the section drives side A only.
- R5: When side B is driven and `sel_ab` is 0, `b_out` equals `a_in` in the same cycle, with no register in the path.
- R6: When side B is driven and `sel_ab` is 1, `b_out` equals the A-to-B stored value.
- R7: On a clock edge where `stb_ab` is 1 and was 0 at the previous edge, `a_in` is stored in the A-to-B register. On every other edge that register keeps its value, including while `stb_ab` stays high.
- R8: The B-to-A path mirrors R5 to R7. `sel_ba` 0 gives live `b_in` on `a_out`, and `sel_ba` 1 gives the B-to-A stored value. A rising `stb_ba` stores `b_in`.
- R9: Capture on either path happens whatever the values of `oe_n` and `dir`, including when both sides are isolated. Both registers may capture on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_n | input | 1 | Active-low output enable for the section |
| dir | input | 1 | 1: drive side B from A; 0: drive side A from B |
| stb_ab | input | 1 | Capture strobe for the A-to-B register (rising edge) |
| stb_ba | input | 1 | Capture strobe for the B-to-A register (rising edge) |
| sel_ab | input | 1 | 0: live A to side B; 1: stored A to side B |
| sel_ba | input | 1 | 0: live B to side A; 1: stored B to side A |
| a_in | input | W | Value present on bus A |
| b_in | input | W | Value present on bus B |
| a_out | output | W | Value to drive onto bus A (zero when not driven) |
| a_oe | output | 1 | Drive enable for bus A |
| b_out | output | W | Value to drive onto bus B (zero when not driven) |
| b_oe | output | 1 | Drive enable for bus B |

## Verification
Directed cases go through each bus-management function in turn:
- isolation;
- live and stored transfer in each direction;
- storing into both registers while isolated;
- replay of stored data after a direction flip.

Storing while isolated, then replaying, separates capture that ignores the enables from capture gated by them. A strobe held high for many cycles while the bus changes separates edge capture from level capture. After that, random cycles with a fixed seed mix enable, direction, selects, strobes and bus data. The driven side's value loops back as its input, so a value stored from a driven bus must equal what the section itself put on it.

// File: rtl/bidir_xcvr_pkg.sv
// Package: shared types for the registered bidirectional transceiver section.
// Assumes nothing beyond being compiled ahead of the modules that import it.
package bidir_xcvr_pkg;

    // Source chosen for an outgoing path.
    typedef enum logic {
        PATH_LIVE   = 1'b0,
        PATH_STORED = 1'b1
    } path_src_e;

    // Which bus the section currently drives.
    typedef struct packed {
        logic drive_a;
        logic drive_b;
    } drive_t;

endpackage

// File: rtl/bidir_xcvr_cap.sv
// Module: bidir_xcvr_cap
// Storage for one direction. It detects a rising edge of the capture strobe
// in the clk domain and loads the data on that same clk edge.
// Assumes the strobe is synchronous to clk and stays low or high for at
// least one clk cycle. A strobe already high when reset is released counts
// as a rising edge at the first edge afterwards.
module bidir_xcvr_cap #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic stb_prev;
    logic take;

    // Capture fires only on the first cycle the strobe is seen high.
    assign take = stb & ~stb_prev;

    // Track the strobe level from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_prev <= 1'b0;
        else        stb_prev <= stb;
    end

    // Load the stored copy on a detected edge, otherwise hold it.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (take) q <= d;
    end

endmodule

// File: rtl/bidir_xcvr_dirctl.sv
// Module: bidir_xcvr_dirctl
// Decodes the active-low enable and the direction into per-side drive
// enables. At most one side is ever enabled.
// Assumes purely combinational use; no state.
module bidir_xcvr_dirctl
    import bidir_xcvr_pkg::*;
(
    input  logic   oe_n,
    input  logic   dir,
    output drive_t drv
);

    // Pick the driven side from enable and direction.
    always_comb begin
        drv.drive_b = ~oe_n &  dir;
        drv.drive_a = ~oe_n & ~dir;
    end

endmodule

// File: rtl/bidir_xcvr_path.sv
// Module: bidir_xcvr_path
// Output selector for one direction. It picks the live input or the stored
// copy and forces zero whenever the target side is not driven.
// Assumes the stored copy comes from bidir_xcvr_cap of the same direction.
module bidir_xcvr_path
    import bidir_xcvr_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         en,
    input  path_src_e    src,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] y
);

    // Select the source, then gate it with the drive enable.
    always_comb begin
        if (!en)                     y = '0;
        else if (src == PATH_STORED) y = stored;
        else                         y = live;
    end

endmodule

// File: rtl/bidir_xcvr_sec.sv
// Module: bidir_xcvr_sec (top)
// One section of a registered bidirectional bus transceiver. It has one
// storage register per direction, a live/stored selector per output, and
// direction/isolation control.
// Assumes all controls are synchronous to clk. The drive enables are
// resolved into real bus drive outside this block.
module bidir_xcvr_sec
    import bidir_xcvr_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         oe_n,
    input  logic         dir,
    input  logic         stb_ab,
    input  logic         stb_ba,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);

    localparam int NDIR = 2;    // path 0: A to B, path 1: B to A

    drive_t              drv;
    logic [W-1:0]        st_ab;
    logic [W-1:0]        st_ba;
    logic [NDIR-1:0]     p_stb;
    logic [NDIR-1:0]     p_sel;
    logic [NDIR-1:0]     p_en;
    logic [W-1:0]        p_d   [NDIR];
    logic [W-1:0]        p_q   [NDIR];
    logic [W-1:0]        p_y   [NDIR];

    bidir_xcvr_dirctl u_dirctl (
        .oe_n (oe_n),
        .dir  (dir),
        .drv  (drv)
    );

    // Arrange the per-direction controls so both paths share one structure.
    always_comb begin
        p_stb = {stb_ba, stb_ab};
        p_sel = {sel_ba, sel_ab};
        p_en  = {drv.drive_a, drv.drive_b};
        p_d[0] = a_in;
        p_d[1] = b_in;
    end

    for (genvar g = 0; g < NDIR; g++) begin : g_path
        bidir_xcvr_cap #(.W(W)) u_cap (
            .clk   (clk),
            .rst_n (rst_n),
            .stb   (p_stb[g]),
            .d     (p_d[g]),
            .q     (p_q[g])
        );

        bidir_xcvr_path #(.W(W)) u_sel (
            .en     (p_en[g]),
            .src    (path_src_e'(p_sel[g])),
            .live   (p_d[g]),
            .stored (p_q[g]),
            .y      (p_y[g])
        );
    end

    // Map the generic paths back onto the named sides.
    always_comb begin
        st_ab = p_q[0];
        st_ba = p_q[1];
        b_out = p_y[0];
        a_out = p_y[1];
        b_oe  = drv.drive_b;
        a_oe  = drv.drive_a;
    end

endmodule

// File: rtl/bidir_xcvr_sec_chk.sv
// Module: bidir_xcvr_sec_chk
// Property checker bound to bidir_xcvr_sec. It sees the ports and the two
// stored copies, and keeps its own record of the previous strobe levels.
module bidir_xcvr_sec_chk #(
    parameter int W = 9
) (
    input logic         clk,
    input logic         rst_n,
    input logic         oe_n,
    input logic         dir,
    input logic         stb_ab,
    input logic         stb_ba,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_out,
    input logic         b_oe,
    input logic [W-1:0] st_ab,
    input logic [W-1:0] st_ba
);

    logic ck_ab_prev;
    logic ck_ba_prev;

    // Previous strobe levels as seen by the checker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_ab_prev <= 1'b0;
            ck_ba_prev <= 1'b0;
        end else begin
            ck_ab_prev <= stb_ab;
            ck_ba_prev <= stb_ba;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (st_ab == '0 && st_ba == '0)); // R1
    AST_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n) oe_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0)); // R2
    AST_DRIVE_B_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (!oe_n && dir) |-> (b_oe && !a_oe)); // R3
    AST_DRIVE_A_ONLY: assert property (@(posedge clk) disable iff (!rst_n) (!oe_n && !dir) |-> (a_oe && !b_oe)); // R4
    AST_LIVE_AB: assert property (@(posedge clk) disable iff (!rst_n) (b_oe && !sel_ab) |-> b_out == a_in); // R5
    AST_STORED_AB: assert property (@(posedge clk) disable iff (!rst_n) (b_oe && sel_ab) |-> b_out == st_ab); // R6
    AST_CAPTURE_AB: assert property (@(posedge clk) disable iff (!rst_n) (stb_ab && !ck_ab_prev) |=> st_ab == $past(a_in)); // R7
    AST_HOLD_AB: assert property (@(posedge clk) disable iff (!rst_n) !(stb_ab && !ck_ab_prev) |=> $stable(st_ab)); // R7
    AST_PATH_BA: assert property (@(posedge clk) disable iff (!rst_n) a_oe |-> a_out == (sel_ba ? st_ba : b_in)); // R8
    AST_CAPTURE_BA: assert property (@(posedge clk) disable iff (!rst_n) (stb_ba && !ck_ba_prev) |=> st_ba == $past(b_in)); // R8
    AST_HOLD_BA: assert property (@(posedge clk) disable iff (!rst_n) !(stb_ba && !ck_ba_prev) |=> $stable(st_ba)); // R8
    AST_CAPTURE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n) (oe_n && stb_ab && !ck_ab_prev) |=> st_ab == $past(a_in)); // R9

endmodule

bind bidir_xcvr_sec bidir_xcvr_sec_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .oe_n   (oe_n),
    .dir    (dir),
    .stb_ab (stb_ab),
    .stb_ba (stb_ba),
    .sel_ab (sel_ab),
    .sel_ba (sel_ba),
    .a_in   (a_in),
    .b_in   (b_in),
    .a_out  (a_out),
    .a_oe   (a_oe),
    .b_out  (b_out),
    .b_oe   (b_oe),
    .st_ab  (st_ab),
    .st_ba  (st_ba)
);

// File: tb/tb_bidir_xcvr_sec.sv
module tb_bidir_xcvr_sec;

    localparam int W          = 9;
    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 3000;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         oe_n, dir, stb_ab, stb_ba, sel_ab, sel_ba;
    logic [W-1:0] a_ext, b_ext;
    logic [W-1:0] a_bus, b_bus;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    int n_total = 0;
    int n_bad   = 0;

    // Bench model state, built from the requirements.
    logic [W-1:0] m_ab, m_ba;
    logic         m_pab, m_pba;
    logic         m_rst_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    // A driven side loops back as that side's input.
    assign a_bus = a_oe ? a_out : a_ext;
    assign b_bus = b_oe ? b_out : b_ext;

    bidir_xcvr_sec #(.W(W)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .oe_n   (oe_n),
        .dir    (dir),
        .stb_ab (stb_ab),
        .stb_ba (stb_ba),
        .sel_ab (sel_ab),
        .sel_ba (sel_ba),
        .a_in   (a_bus),
        .b_in   (b_bus),
        .a_out  (a_out),
        .a_oe   (a_oe),
        .b_out  (b_out),
        .b_oe   (b_oe)
    );

    function automatic logic [W-1:0] exp_bout(logic en, logic sel, logic [W-1:0] live, logic [W-1:0] st);
        if (!en) return '0;
        return sel ? st : live;
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle: set inputs, check outputs mid-cycle, step the model at the edge.
    task automatic cyc(logic i_oe_n, logic i_dir, logic i_sab, logic i_sba,
                       logic i_stab, logic i_stba, logic [W-1:0] i_a, logic [W-1:0] i_b);
        logic         eb, ea;
        logic [W-1:0] eb_out, ea_out, ea_bus, eb_bus;
        @(negedge clk);
        oe_n = i_oe_n; dir = i_dir; sel_ab = i_sab; sel_ba = i_sba;
        stb_ab = i_stab; stb_ba = i_stba; a_ext = i_a; b_ext = i_b;
        #1;
        eb = !i_oe_n && i_dir;
        ea = !i_oe_n && !i_dir;
        // Only one side is driven, so the live source is its external value.
        eb_out = exp_bout(eb, i_sab, i_a, m_ab);
        ea_out = exp_bout(ea, i_sba, i_b, m_ba);
        ea_bus = ea ? ea_out : i_a;
        eb_bus = eb ? eb_out : i_b;
        if (i_oe_n) begin
            chk("R2 a_oe", W'(a_oe), '0);
            chk("R2 b_oe", W'(b_oe), '0);
        end else if (i_dir) begin
            chk("R3 b_oe", W'(b_oe), W'(1));
            chk("R3 a_oe", W'(a_oe), '0);
        end else begin
            chk("R4 a_oe", W'(a_oe), W'(1));
            chk("R4 b_oe", W'(b_oe), '0);
        end
        if (eb) chk(i_sab ? "R6 b_out stored" : "R5 b_out live", b_out, eb_out);
        else    chk("R2 b_out zero", b_out, eb_out);
        if (ea) chk("R8 a_out", a_out, ea_out);
        else    chk("R2 a_out zero", a_out, ea_out);
        @(posedge clk);
        // R7 / R8 / R9: edge-detected capture, independent of enable.
        if (i_stab && !m_pab) m_ab = ea_bus;
        if (i_stba && !m_pba) m_ba = eb_bus;
        m_pab = i_stab;
        m_pba = i_stba;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        m_ab = '0; m_ba = '0; m_pab = 1'b0; m_pba = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_total++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h1a2b;
        void'($urandom(seed));
        rst_n = 1'b0; oe_n = 1'b1; dir = 1'b0; sel_ab = 1'b0; sel_ba = 1'b0;
        stb_ab = 1'b0; stb_ba = 1'b0; a_ext = '0; b_ext = '0;
        m_ab = 'x; m_ba = 'x; m_pab = 1'b0; m_pba = 1'b0; m_rst_seen = 1'b0;
        repeat (2) @(posedge clk);
        do_reset();

        // R1: stored paths read zero right after reset.
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9'h1aa, 9'h055);
        chk("R1 reset A-to-B store", m_ab, '0);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 9'h1aa, 9'h055);

        // R9: store both while isolated, then replay each way.
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 9'h123, 9'h0f0);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000, 9'h1ff);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9'h000, 9'h000);
        chk("R9 isolated capture A", m_ab, 9'h123);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 9'h000, 9'h000);
        chk("R9 isolated capture B", m_ba, 9'h0f0);

        // R5: live A to B follows A every cycle.
        for (int i = 0; i < 4; i++)
            cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, W'(9'h101 << i), 9'h000);

        // R7: held strobe level must not recapture.
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 9'h0aa, 9'h000);
        for (int i = 0; i < 4; i++)
            cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, W'(i + 9'h150), 9'h000);
        chk("R7 level does not recapture", m_ab, 9'h0aa);

        // R8: store B while side A is driven live, then check stored replay.
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h000, 9'h16c);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 9'h000, 9'h000);
        chk("R8 B capture", m_ba, 9'h16c);

        // Store A from the looped-back driven bus: A driven with stored B.
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 9'h000, 9'h000);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9'h000, 9'h000);
        chk("R7 capture of driven loopback", m_ab, 9'h16c);

        // R1: mid-run reset clears loaded registers.
        do_reset();
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9'h1ff, 9'h1ff);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 9'h1ff, 9'h1ff);

        // Random mix.
        for (int i = 0; i < N_RAND; i++) begin
            logic [7:0] r;
            r = 8'($urandom);
            cyc(r[0] & r[1], r[2], r[3], r[4], r[5], r[6],
                W'($urandom), W'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule